// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps wall-clock time and calendar date as eight packed-BCD bytes: hundredths of a second, seconds, minutes, hours, weekday, day of month, month and two-digit year. A one-cycle enable pulse at 100 Hz advances the count. One tick can ripple through every field in a single clock, for example at the end of a year. The day of month wraps according to the month length. February takes a 29th day when the year value is a multiple of four.

An access port loads any register as a whole byte, and a combinational read port returns any register by index. The hours byte switches between a 24-hour count and a 12-hour count with a PM flag. The weekday byte also holds two control flags. One flag stops timekeeping. The other decides whether an external reset pin may raise a transfer-abort output.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the registers read, by index 0 to 7: 00, 00, 00, 00 (24-hour midnight), 31, 01, 01, 00. Weekday bits 5 and 4 both come up as 1, so the clock is stopped and the reset pin is masked.
- R2: Register 0 counts hundredths 00 to 99 in BCD, with tenths in the upper nibble. It advances on a tick when no write occurs and weekday bit 5 is 0. At 99 it wraps to 00 and carries into register 1.
- R3: Registers 1 (seconds) and 2 (minutes) count 00 to 59. Each advances only on the carry from the field below and passes its own carry upward at 59.
- R4: With hours bit 7 at 0 (24-hour mode), hours count 00 to 23 with bit 5 as the 20s digit. The step from 23 to 00 carries into the weekday and the date.
- R5: With hours bit 7 at 1 (12-hour mode), bits 4:0 run 12, 01 through 11. Bit 5 is PM and toggles on the step from 11 to 12. Only the step from 11 PM to 12 AM carries into the weekday and the date.
- R6: Weekday bits 2:0 step with every date carry and wrap from 7 to 1. All other bits of that register keep their value.
- R7: On a date carry, a date at or above the month's last day becomes 01 and carries into the month. April, June, September and November end at 30. February ends at 29 when the year value is divisible by 4 and at 28 otherwise. All other months end at 31.
- R8: Register 6 (month) counts 01 to 12 and its wrap from 12 to 01 advances register 7 (year). The year wraps from 99 to 00.
- R9: While weekday bit 5 is 1, ticks change no register.
- R10: A write with wr_en loads wr_data into register wr_idx at the next edge. A tick in the same cycle is discarded for every register.
- R11: xfer_abort is high when ext_rst_n is low and weekday bit 4 is 0. When bit 4 is 1, ext_rst_n is ignored and xfer_abort stays low.
- R12: rd_data shows register rd_idx combinationally, using the index order of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle pulse per hundredth of a second |
| wr_en | input | 1 | Byte write strobe |
| wr_idx | input | 3 | Register index to load |
| wr_data | input | 8 | Byte to load |
| rd_idx | input | 3 | Register index to read |
| rd_data | output | 8 | Selected register byte |
| ext_rst_n | input | 1 | External active-low reset request pin |
| xfer_abort | output | 1 | Abort request for an access in progress |

## Verification
The two functions that can land in one cycle are a port write and a tick increment. Directed cases provoke the collision with hundredths at 98 and at 99. At 99 a tick would otherwise ripple into seconds, so the cases show whether the write drops the whole tick or only the tick for the written byte. Random traffic then mixes writes and ticks freely. A bench model predicts all eight bytes after every cycle. In that model a write cycle changes only the written byte, and a tick applies only in cycles without a write.

// File: rtl/bcd_tk_pkg.sv
package bcd_tk_pkg;

   // Increment of a valid packed BCD byte (no range check).
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Year value (BCD 00..99) divisible by four: (2*tens + units) mod 4 == 0.
   function automatic logic leap_year(input logic [7:0] yr);
      logic [3:0] sum;
      sum = yr[3:0] + {2'b00, yr[4], 1'b0};
      return (sum[1:0] == 2'b00);
   endfunction

   // Last day of a month, as BCD.
   function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   // Range of the plain wrapping fields, by register index.
   function automatic logic [7:0] field_lo(input int idx);
      return (idx == 6) ? 8'h01 : 8'h00;
   endfunction

   function automatic logic [7:0] field_hi(input int idx);
      case (idx)
         0, 7:    return 8'h99;
         1, 2:    return 8'h59;
         6:       return 8'h12;
         default: return 8'h00;
      endcase
   endfunction

   // Value each register holds after reset.
   function automatic logic [7:0] reset_value(input int idx, input logic ctrl);
      case (idx)
         4:       return {2'b00, ctrl, ctrl, 4'h1};
         5, 6:    return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/tk_bcd_wrap.sv
module tk_bcd_wrap
   import bcd_tk_pkg::*;
#(
   parameter logic [7:0] LO = 8'h00,
   parameter logic [7:0] HI = 8'h99
) (
   input  logic [7:0] cur,
   input  logic       step,
   output logic [7:0] nxt,
   output logic       carry
);
   logic at_top;
   assign at_top = (cur >= HI);
   assign carry  = step && at_top;
   assign nxt    = !step ? cur : (at_top ? LO : bcd_inc(cur));
endmodule

// File: rtl/tk_hour_step.sv
module tk_hour_step
   import bcd_tk_pkg::*;
(
   input  logic [7:0] cur,
   input  logic       step,
   output logic [7:0] nxt,
   output logic       carry
);
   always_comb begin
      nxt   = cur;
      carry = 1'b0;
      if (step) begin
         if (cur[7]) begin
            // 12-hour: 12, 01 .. 11; PM toggles entering 12
            if (cur[4:0] == 5'h11) begin
               nxt   = {cur[7:6], ~cur[5], 5'h12};
               carry = cur[5];
            end else if (cur[4:0] >= 5'h12) begin
               nxt = {cur[7:5], 5'h01};
            end else begin
               nxt = {cur[7:5], 5'(bcd_inc({3'b000, cur[4:0]}))};
            end
         end else begin
            if (cur[5:0] >= 6'h23) begin
               nxt   = {cur[7:6], 6'h00};
               carry = 1'b1;
            end else begin
               nxt = {cur[7:6], 6'(bcd_inc({2'b00, cur[5:0]}))};
            end
         end
      end
   end
endmodule

// File: rtl/tk_wday_step.sv
module tk_wday_step (
   input  logic [7:0] cur,
   input  logic       step,
   output logic [7:0] nxt,
   output logic       carry
);
   logic [2:0] wd_next;
   assign wd_next = (cur[2:0] >= 3'd7) ? 3'd1 : cur[2:0] + 3'd1;
   assign nxt     = step ? {cur[7:3], wd_next} : cur;
   // The date advances together with the weekday.
   assign carry   = step;
endmodule

// File: rtl/tk_date_step.sv
module tk_date_step
   import bcd_tk_pkg::*;
(
   input  logic [7:0] cur,
   input  logic       step,
   input  logic [7:0] month,
   input  logic [7:0] year,
   output logic [7:0] nxt,
   output logic       carry
);
   logic at_end;
   assign at_end = (cur >= month_last(month, year));
   assign carry  = step && at_end;
   assign nxt    = !step ? cur : (at_end ? 8'h01 : bcd_inc(cur));
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
   import bcd_tk_pkg::*;
#(
   parameter int  NUM_REGS  = 8,
   parameter int  REG_W     = 8,
   parameter bit  CTRL_INIT = 1'b1,
   localparam int IDX_W     = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_100hz,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [REG_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [REG_W-1:0] rd_data,
   input  logic             ext_rst_n,
   output logic             xfer_abort
);
   localparam int WDAY_IDX = 4;
   localparam int OSC_BIT  = 5;
   localparam int RSTE_BIT = 4;

   if (NUM_REGS != 8) begin : g_bad_count
      $error("bcd_timekeeper: NUM_REGS must be 8");
   end
   if (REG_W != 8) begin : g_bad_width
      $error("bcd_timekeeper: REG_W must be 8");
   end

   logic [NUM_REGS-1:0][REG_W-1:0] regs;
   logic [NUM_REGS-1:0][REG_W-1:0] nxt_v;
   logic [NUM_REGS-1:0]            carry_v;
   logic [NUM_REGS-1:0]            step_v;
   logic                           adv;
   logic                           unused_year_carry;

   // A write cycle discards the tick for all fields.
   assign adv    = tick_100hz && !regs[WDAY_IDX][OSC_BIT] && !wr_en;
   assign step_v = {carry_v[NUM_REGS-2:0], adv};
   assign unused_year_carry = carry_v[NUM_REGS-1];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_field
      if (g == 3) begin : g_hour
         tk_hour_step u_step (
            .cur(regs[g]), .step(step_v[g]), .nxt(nxt_v[g]), .carry(carry_v[g]));
      end else if (g == WDAY_IDX) begin : g_wday
         tk_wday_step u_step (
            .cur(regs[g]), .step(step_v[g]), .nxt(nxt_v[g]), .carry(carry_v[g]));
      end else if (g == 5) begin : g_date
         tk_date_step u_step (
            .cur(regs[g]), .step(step_v[g]), .month(regs[6]), .year(regs[7]),
            .nxt(nxt_v[g]), .carry(carry_v[g]));
      end else begin : g_wrap
         tk_bcd_wrap #(.LO(field_lo(g)), .HI(field_hi(g))) u_step (
            .cur(regs[g]), .step(step_v[g]), .nxt(nxt_v[g]), .carry(carry_v[g]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= reset_value(i, CTRL_INIT);
      end else if (wr_en) begin
         regs[wr_idx] <= wr_data;
      end else begin
         regs <= nxt_v;
      end
   end

   assign rd_data    = regs[rd_idx];
   assign xfer_abort = !ext_rst_n && !regs[WDAY_IDX][RSTE_BIT];
endmodule

// File: rtl/bcd_timekeeper_chk.sv
module bcd_timekeeper_chk (
   input logic            clk,
   input logic            rst_n,
   input logic            tick_100hz,
   input logic            wr_en,
   input logic [2:0]      wr_idx,
   input logic [7:0]      wr_data,
   input logic            ext_rst_n,
   input logic            xfer_abort,
   input logic [7:0][7:0] regs
);
   p_hund_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_100hz && !wr_en && !regs[4][5] && regs[0] == 8'h99) |=> regs[0] == 8'h00);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_100hz && !wr_en) |=> $stable(regs));

   p_sec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && regs[0] != 8'h99) |=> $stable(regs[1]));

   p_wday_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && regs[5] != $past(regs[5])) |-> regs[4][2:0] != $past(regs[4][2:0]));

   p_year_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && regs[6] != 8'h12) |=> $stable(regs[7]));

   p_osc_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (regs[4][5] && !wr_en) |=> $stable(regs));

   p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> regs[$past(wr_idx)] == $past(wr_data));

   p_abort_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      regs[4][4] |-> !xfer_abort);

   p_abort_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!regs[4][4] && !ext_rst_n) |-> xfer_abort);
endmodule

bind bcd_timekeeper bcd_timekeeper_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .wr_en(wr_en),
   .wr_idx(wr_idx), .wr_data(wr_data), .ext_rst_n(ext_rst_n),
   .xfer_abort(xfer_abort), .regs(regs));

// File: tb/bcd_timekeeper_test.sv
`timescale 1ns/10ps
module bcd_timekeeper_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_100hz = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_idx = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_idx = '0;
   logic [7:0] rd_data;
   logic       ext_rst_n = 1'b1;
   logic       xfer_abort;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] m [8];

   always #2 clk = ~clk;

   bcd_timekeeper uut (
      .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .ext_rst_n(ext_rst_n), .xfer_abort(xfer_abort));

   function automatic int b2i(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      logic [3:0] t, u;
      t = 4'(v / 10);
      u = 4'(v % 10);
      return {t, u};
   endfunction

   function automatic string req_of(input int i);
      case (i)
         0:       return "R2";
         1, 2:    return "R3";
         3:       return "R4/R5";
         4:       return "R6";
         5:       return "R7";
         default: return "R8";
      endcase
   endfunction

   // Bench model: binary arithmetic on the decoded fields.
   task automatic model_tick();
      int h, hr, wd, d, mo, yr, last;
      logic pm, dc;
      logic [7:0] t;
      if (m[4][5]) return;
      h = b2i(m[0]) + 1;
      if (h < 100) begin m[0] = i2b(h); return; end
      m[0] = 8'h00;
      h = b2i(m[1]) + 1;
      if (h < 60) begin m[1] = i2b(h); return; end
      m[1] = 8'h00;
      h = b2i(m[2]) + 1;
      if (h < 60) begin m[2] = i2b(h); return; end
      m[2] = 8'h00;
      if (m[3][7]) begin
         hr = b2i({3'b000, m[3][4:0]});
         pm = m[3][5];
         dc = 1'b0;
         if (hr == 11) begin hr = 12; dc = pm; pm = !pm; end
         else if (hr == 12) hr = 1;
         else hr = hr + 1;
         t = i2b(hr);
         m[3] = {m[3][7:6], pm, t[4:0]};
         if (!dc) return;
      end else begin
         hr = b2i({2'b00, m[3][5:0]});
         if (hr < 23) begin
            t = i2b(hr + 1);
            m[3] = {m[3][7:6], t[5:0]};
            return;
         end
         m[3] = {m[3][7:6], 6'h00};
      end
      wd = int'(m[4][2:0]);
      wd = (wd >= 7) ? 1 : wd + 1;
      m[4][2:0] = 3'(wd);
      mo = b2i(m[6]);
      yr = b2i(m[7]);
      if (mo == 2) last = (yr % 4 == 0) ? 29 : 28;
      else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) last = 30;
      else last = 31;
      d = b2i(m[5]);
      if (d < last) begin m[5] = i2b(d + 1); return; end
      m[5] = 8'h01;
      if (mo < 12) begin m[6] = i2b(mo + 1); return; end
      m[6] = 8'h01;
      m[7] = (yr < 99) ? i2b(yr + 1) : 8'h00;
   endtask

   task automatic check_byte(input int idx, input logic [7:0] exp, input string req);
      rd_idx = 3'(idx);
      #0.1;
      n_chk++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s reg%0d actual %h expected %h", req, idx, rd_data, exp);
      end
   endtask

   task automatic check_abort(input logic exp);
      #0.1;
      n_chk++;
      if (xfer_abort !== exp) begin
         n_bad++;
         $display("FAIL R11 xfer_abort actual %b expected %b", xfer_abort, exp);
      end
   endtask

   task automatic check_model();
      for (int i = 0; i < 8; i++) check_byte(i, m[i], req_of(i));
      check_abort(!ext_rst_n && !m[4][4]);
   endtask

   // One clock: drive, wait for the edge, update the model.
   task automatic cyc(input logic tk, input logic wr, input int idx, input logic [7:0] val);
      tick_100hz = tk;
      wr_en      = wr;
      wr_idx     = 3'(idx);
      wr_data    = val;
      @(posedge clk);
      #1;
      if (wr) m[idx] = val;
      else if (tk) model_tick();
      tick_100hz = 1'b0;
      wr_en      = 1'b0;
   endtask

   task automatic set_all(input logic [7:0] v0, v1, v2, v3, v4, v5, v6, v7);
      cyc(0, 1, 0, v0); cyc(0, 1, 1, v1); cyc(0, 1, 2, v2); cyc(0, 1, 3, v3);
      cyc(0, 1, 4, v4); cyc(0, 1, 5, v5); cyc(0, 1, 6, v6); cyc(0, 1, 7, v7);
   endtask

   function automatic logic [7:0] rand_val(input int idx);
      logic hi_end;
      hi_end = ($urandom % 2) == 0;
      case (idx)
         0: return hi_end ? i2b(99 - int'($urandom % 3)) : i2b(int'($urandom % 100));
         1, 2: return hi_end ? i2b(59 - int'($urandom % 2)) : i2b(int'($urandom % 60));
         3: if ($urandom % 2)
               return {1'b1, 1'b0, 1'($urandom), 5'(i2b(hi_end ? 11 : 1 + int'($urandom % 12)))};
            else
               return {2'b00, 6'(i2b(hi_end ? 23 : int'($urandom % 24)))};
         4: return {2'b00, ($urandom % 16) == 0, 1'($urandom), 1'b0, 3'(1 + $urandom % 7)};
         5: return hi_end ? i2b(28 + int'($urandom % 4)) : i2b(1 + int'($urandom % 31));
         6: return hi_end ? 8'h12 : i2b(1 + int'($urandom % 12));
         default: return hi_end ? 8'h99 : i2b(int'($urandom % 100));
      endcase
   endfunction

   initial begin
      #(4 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: reset state
      check_byte(0, 8'h00, "R1"); check_byte(1, 8'h00, "R1");
      check_byte(2, 8'h00, "R1"); check_byte(3, 8'h00, "R1");
      check_byte(4, 8'h31, "R1"); check_byte(5, 8'h01, "R1");
      check_byte(6, 8'h01, "R1"); check_byte(7, 8'h00, "R1");
      m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h00;
      m[4] = 8'h31; m[5] = 8'h01; m[6] = 8'h01; m[7] = 8'h00;
      // R11: masked after reset
      ext_rst_n = 1'b0;
      check_abort(1'b0);
      // R9: stopped clock ignores ticks
      cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
      check_byte(0, 8'h00, "R9");
      check_byte(4, 8'h31, "R9");
      // R11: unmask, run oscillator
      cyc(0, 1, 4, 8'h03);
      check_abort(1'b1);
      ext_rst_n = 1'b1;
      check_abort(1'b0);
      // R12: distinct bytes read back by index
      set_all(8'h42, 8'h17, 8'h33, 8'h08, 8'h05, 8'h19, 8'h07, 8'h58);
      check_byte(0, 8'h42, "R12"); check_byte(1, 8'h17, "R12");
      check_byte(2, 8'h33, "R12"); check_byte(3, 8'h08, "R12");
      check_byte(4, 8'h05, "R12"); check_byte(5, 8'h19, "R12");
      check_byte(6, 8'h07, "R12"); check_byte(7, 8'h58, "R12");
      // R4 R6 R7: 24h midnight, Feb 28 in non-leap year, weekday 7
      set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
      cyc(1, 0, 0, 0);
      check_byte(3, 8'h00, "R4"); check_byte(4, 8'h01, "R6");
      check_byte(5, 8'h01, "R7"); check_byte(6, 8'h03, "R7");
      // R7: leap year February 28 -> 29 -> March 1
      set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h12, 8'h28, 8'h02, 8'h24);
      cyc(1, 0, 0, 0);
      check_byte(5, 8'h29, "R7"); check_byte(4, 8'h13, "R6");
      cyc(0, 1, 0, 8'h99); cyc(0, 1, 1, 8'h59); cyc(0, 1, 2, 8'h59); cyc(0, 1, 3, 8'h23);
      cyc(1, 0, 0, 0);
      check_byte(5, 8'h01, "R7"); check_byte(6, 8'h03, "R7");
      // R7: April 30 -> May 1
      set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
      cyc(1, 0, 0, 0);
      check_byte(5, 8'h01, "R7"); check_byte(6, 8'h05, "R7");
      // R8: end of year 99
      set_all(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h99);
      cyc(1, 0, 0, 0);
      check_byte(6, 8'h01, "R8"); check_byte(7, 8'h00, "R8");
      check_byte(0, 8'h00, "R2"); check_byte(1, 8'h00, "R3");
      // R5: 12-hour sequence
      set_all(8'h99, 8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h06, 8'h05);
      cyc(1, 0, 0, 0);
      check_byte(3, 8'hB2, "R5"); check_byte(5, 8'h10, "R5");
      cyc(0, 1, 0, 8'h99); cyc(0, 1, 1, 8'h59); cyc(0, 1, 2, 8'h59);
      cyc(1, 0, 0, 0);
      check_byte(3, 8'hA1, "R5");
      cyc(0, 1, 3, 8'hB1); cyc(0, 1, 0, 8'h99); cyc(0, 1, 1, 8'h59); cyc(0, 1, 2, 8'h59);
      cyc(1, 0, 0, 0);
      check_byte(3, 8'h92, "R5"); check_byte(5, 8'h11, "R5");
      check_byte(4, 8'h03, "R6");
      // R10: write collides with tick
      cyc(0, 1, 0, 8'h98);
      cyc(1, 1, 1, 8'h30);
      check_byte(0, 8'h98, "R10"); check_byte(1, 8'h30, "R10");
      cyc(0, 1, 0, 8'h99);
      cyc(1, 1, 2, 8'h45);
      check_byte(0, 8'h99, "R10"); check_byte(1, 8'h30, "R10");
      check_byte(2, 8'h45, "R10");
      // R9: stop bit set freezes all fields
      cyc(0, 1, 4, 8'h23);
      cyc(1, 0, 0, 0);
      check_byte(0, 8'h99, "R9"); check_byte(1, 8'h30, "R9");
      check_model();
      // Random mix
      for (int k = 0; k < 15000; k++) begin
         logic tk, wr;
         int idx;
         tk  = ($urandom % 4) != 0;
         wr  = ($urandom % 8) == 0;
         idx = int'($urandom % 8);
         ext_rst_n = ($urandom % 4) != 0;
         cyc(tk, wr, idx, rand_val(idx));
         check_model();
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule